// File: doc/BRIEF.md
# Overlapping Grid Scan Controller

This controller refreshes a dot-matrix vacuum fluorescent panel whose anodes sit so close together that two neighbouring grids must conduct at once for even brightness. A refresh cycle is made of one time slot per grid. In each slot a pair of adjacent grids is lit, and the pair moves on by one grid per slot. The first slot of the cycle lights the last grid together with the first.

During every slot the controller reads one anode column from a frame-buffer read port. It shifts the column, most significant bit first, over a serial line that two anode drivers share. The shift clock, data and latch lines are common to both drivers. Each driver has its own active-high blanking input, which acts as its select. One latch pulse at the end of the slot moves the shifted anode data and the new grid position onto the panel together. The blanking inputs switch on the same cycle, so the even anode set and the odd anode set take turns from slot to slot. The grid driver has its own serial input. It receives one shift per slot, and the controller feeds it a 1 for the two slots that start the wrap-around.

After reset the controller runs one preparation slot with every output blanked. In that slot it loads a complete grid pattern and the first anode column, and the panel then starts at the first slot.

Top module: `vfd_overlap_scan`

## Requirements
- R1: While `rst` is high and on the cycle after it is sampled, `blank_set_ad`, `blank_set_bc` and `grid_blank` are 1; `anode_lat`, `grid_lat` and `fb_rd_en` are 0; and both shift clocks are 1.
- R2: Once running, a latch pulse lasts one cycle and recurs every `SLOT_CLKS` cycles. `anode_lat` and `grid_lat` always pulse in the same cycle.
- R3: With slots numbered from 0, slot 0 lights grid outputs 1 and `NUM_GRIDS`. Slot s ≥ 1 lights grids s and s+1, counted from 1. Grid driver bit 0 is grid 1, and each shift moves bit i to bit i+1.
- R4: In a running slot the grid shift clock has exactly one rising edge. The data on that edge is 1 only when the next slot is slot 0 or slot 1.
- R5: In every slot the anode shift clock has exactly `NUM_ANODES` rising edges, and the data is valid on each rising edge. Bit `NUM_ANODES-1` of the column goes first, so the latched driver word equals the column.
- R6: Each slot raises `fb_rd_en` for one cycle. `fb_addr` then carries the number of the slot that follows, and `fb_rdata` is taken one cycle after the request.
- R7: Once running, exactly one blanking input is low. `blank_set_ad` is low in even-numbered slots and `blank_set_bc` is low in odd-numbered slots. Blanking changes only in the cycle of the latch pulse.
- R8: Outside a bit transfer both shift clocks rest high. Each bit holds its clock low for exactly one cycle, and both clocks are high during the latch pulse.
- R9: After reset, one preparation slot keeps all blanking high and shifts `NUM_GRIDS` grid bits. The first latch then shows slot 0, and `grid_blank` falls only with a latch pulse.
- R10: A reset asserted in the middle of a slot returns the outputs to the R1 state, and the controller restarts from the preparation slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Frame-buffer read request |
| fb_addr | output | $clog2(NUM_GRIDS) | Column to read (number of the next slot) |
| fb_rdata | input | NUM_ANODES | Column data, valid one cycle after the request |
| anode_sdata | output | 1 | Shared anode serial data |
| anode_sclk | output | 1 | Shared anode shift clock, idle high |
| anode_lat | output | 1 | Shared anode latch pulse |
| blank_set_ad | output | 1 | Blanking of the driver for the A and D anode set, active high |
| blank_set_bc | output | 1 | Blanking of the driver for the B and C anode set, active high |
| grid_sdata | output | 1 | Grid driver serial data |
| grid_sclk | output | 1 | Grid driver shift clock, idle high |
| grid_lat | output | 1 | Grid driver latch pulse |
| grid_blank | output | 1 | Grid driver blanking, high until the first latch |

## Verification
The bench models both shift registers as the panel drivers see them. It checks every slot of several full refresh cycles on an eight-grid configuration, so the wrap from the last slot to slot 0 is crossed more than once. A design that shifted the grid's 1 in the wrong slot would light grid 1 with grid 2 in slot 0, or would leave a third grid on. A design that fetched the current column instead of the next one would show each column one slot late. A swapped blanking parity would enable the B and C anodes over the wrap pair. The bench also counts shift-clock edges and low cycles, including the longer preparation slot. It then asserts a reset part-way through a slot, which would expose a restart that skips the full grid reload.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  // system-clock offset inside a slot where the first serial bit begins
  localparam int unsigned SHIFT_START = 3;

  typedef struct packed {
    logic fetch;   // request the next column
    logic load;    // capture returned column
    logic sh_lo;   // low phase of a serial bit
    logic latch;   // end-of-slot latch
  } scan_strobe_t;

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
  import vfd_scan_pkg::*;
#(
  parameter int NUM_GRIDS  = 64,
  parameter int SLOT_CLKS  = 160,
  parameter int SHIFT_BITS = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  output scan_strobe_t                    stb,
  output logic [$clog2(SHIFT_BITS)-1:0]   bit_idx,
  output logic [$clog2(NUM_GRIDS)-1:0]    next_slot,
  output logic                            running,
  output logic                            blank_set_ad,
  output logic                            blank_set_bc,
  output logic                            grid_blank
);
  localparam int CW = $clog2(SLOT_CLKS);
  localparam int GW = $clog2(NUM_GRIDS);
  localparam int BW = $clog2(SHIFT_BITS);
  localparam logic [CW-1:0] LAST_C  = CW'(SLOT_CLKS - 1);
  localparam logic [CW-1:0] START_C = CW'(SHIFT_START);
  localparam logic [CW-1:0] END_C   = CW'(SHIFT_START + 2 * SHIFT_BITS);
  localparam logic [GW-1:0] TOP_G   = GW'(NUM_GRIDS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] rel;
  logic [GW-1:0] slot;
  logic          in_win;

  always_comb begin
    rel          = cnt - START_C;
    in_win       = (cnt >= START_C) && (cnt < END_C);
    stb.fetch    = (cnt == '0);
    stb.load     = (cnt == CW'(2));
    stb.sh_lo    = in_win && !rel[0];
    stb.latch    = (cnt == LAST_C);
    bit_idx      = BW'(rel >> 1);
    next_slot    = (slot == TOP_G) ? '0 : slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      slot         <= TOP_G;
      running      <= 1'b0;
      blank_set_ad <= 1'b1;
      blank_set_bc <= 1'b1;
      grid_blank   <= 1'b1;
    end else if (stb.latch) begin
      cnt          <= '0;
      slot         <= next_slot;
      running      <= 1'b1;
      grid_blank   <= 1'b0;
      blank_set_ad <= next_slot[0];
      blank_set_bc <= ~next_slot[0];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.latch |=> (cnt != '0));

endmodule

// File: rtl/vfd_anode_shifter.sv
module vfd_anode_shifter
  import vfd_scan_pkg::*;
#(
  parameter int NUM_GRIDS  = 64,
  parameter int NUM_ANODES = 64,
  parameter int SHIFT_BITS = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  scan_strobe_t                   stb,
  input  logic [$clog2(SHIFT_BITS)-1:0]  bit_idx,
  input  logic [$clog2(NUM_GRIDS)-1:0]   next_slot,
  output logic                           fb_rd_en,
  output logic [$clog2(NUM_GRIDS)-1:0]   fb_addr,
  input  logic [NUM_ANODES-1:0]          fb_rdata,
  output logic                           anode_sdata,
  output logic                           anode_sclk,
  output logic                           anode_lat
);
  localparam int BW = $clog2(SHIFT_BITS);
  localparam logic [BW:0] A_LIM = (BW+1)'(NUM_ANODES);

  logic [NUM_ANODES-1:0] shreg;
  logic                  bit_ok;

  assign bit_ok = stb.sh_lo && ({1'b0, bit_idx} < A_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_rd_en    <= 1'b0;
      fb_addr     <= '0;
      shreg       <= '0;
      anode_sdata <= 1'b0;
      anode_sclk  <= 1'b1;
      anode_lat   <= 1'b0;
    end else begin
      fb_rd_en  <= stb.fetch;
      anode_lat <= stb.latch;
      if (stb.fetch) fb_addr <= next_slot;
      if (stb.load) begin
        shreg <= fb_rdata;
      end else if (bit_ok) begin
        shreg <= {shreg[NUM_ANODES-2:0], 1'b0};
      end
      if (bit_ok) begin
        anode_sclk  <= 1'b0;
        anode_sdata <= shreg[NUM_ANODES-1];
      end else begin
        anode_sclk  <= 1'b1;
      end
    end
  end

  assert_anode_sclk_high_at_latch_R8: assert property (@(posedge clk) disable iff (rst)
    anode_lat |-> anode_sclk);
  assert_fetch_single_R6: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en |=> !fb_rd_en);

endmodule

// File: rtl/vfd_grid_feeder.sv
module vfd_grid_feeder #(
  parameter int NUM_GRIDS  = 64,
  parameter int SHIFT_BITS = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sh_lo,
  input  logic                           latch,
  input  logic [$clog2(SHIFT_BITS)-1:0]  bit_idx,
  input  logic [$clog2(NUM_GRIDS)-1:0]   next_slot,
  input  logic                           running,
  output logic                           grid_sdata,
  output logic                           grid_sclk,
  output logic                           grid_lat
);
  localparam int BW = $clog2(SHIFT_BITS);
  localparam int GW = $clog2(NUM_GRIDS);
  localparam logic [BW:0]   G_LIM  = (BW+1)'(NUM_GRIDS);
  localparam logic [BW-1:0] G_LAST = BW'(NUM_GRIDS - 1);

  logic active;
  logic value;

  always_comb begin
    if (running) begin
      // one shift per slot; a 1 enters ahead of slots 0 and 1
      active = sh_lo && (bit_idx == '0);
      value  = (next_slot == '0) || (next_slot == GW'(1));
    end else begin
      // preparation: full pattern, first bit lands on the last grid
      active = sh_lo && ({1'b0, bit_idx} < G_LIM);
      value  = (bit_idx == '0) || (bit_idx == G_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grid_sdata <= 1'b0;
      grid_sclk  <= 1'b1;
      grid_lat   <= 1'b0;
    end else begin
      grid_lat <= latch;
      if (active) begin
        grid_sclk  <= 1'b0;
        grid_sdata <= value;
      end else begin
        grid_sclk  <= 1'b1;
      end
    end
  end

  assert_grid_sclk_high_at_latch_R8: assert property (@(posedge clk) disable iff (rst)
    grid_lat |-> grid_sclk);

endmodule

// File: rtl/vfd_overlap_scan.sv
module vfd_overlap_scan
  import vfd_scan_pkg::*;
#(
  parameter int NUM_GRIDS  = 64,
  parameter int NUM_ANODES = 64,
  parameter int SLOT_CLKS  = 160
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic                          fb_rd_en,
  output logic [$clog2(NUM_GRIDS)-1:0]  fb_addr,
  input  logic [NUM_ANODES-1:0]         fb_rdata,
  output logic                          anode_sdata,
  output logic                          anode_sclk,
  output logic                          anode_lat,
  output logic                          blank_set_ad,
  output logic                          blank_set_bc,
  output logic                          grid_sdata,
  output logic                          grid_sclk,
  output logic                          grid_lat,
  output logic                          grid_blank
);
  localparam int SHIFT_BITS = (NUM_ANODES > NUM_GRIDS) ? NUM_ANODES : NUM_GRIDS;
  localparam int BW = $clog2(SHIFT_BITS);
  localparam int GW = $clog2(NUM_GRIDS);

  if (SLOT_CLKS < 2 * SHIFT_BITS + 4 || (NUM_GRIDS % 2) != 0 || NUM_GRIDS < 4
      || NUM_ANODES < 2) begin : g_bad_cfg
    $error("vfd_overlap_scan: slot too short or grid count not even");
  end

  scan_strobe_t  stb;
  logic [BW-1:0] bit_idx;
  logic [GW-1:0] next_slot;
  logic          running;

  vfd_slot_timer #(
    .NUM_GRIDS (NUM_GRIDS),
    .SLOT_CLKS (SLOT_CLKS),
    .SHIFT_BITS(SHIFT_BITS)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .bit_idx     (bit_idx),
    .next_slot   (next_slot),
    .running     (running),
    .blank_set_ad(blank_set_ad),
    .blank_set_bc(blank_set_bc),
    .grid_blank  (grid_blank)
  );

  vfd_anode_shifter #(
    .NUM_GRIDS (NUM_GRIDS),
    .NUM_ANODES(NUM_ANODES),
    .SHIFT_BITS(SHIFT_BITS)
  ) u_anode (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .bit_idx    (bit_idx),
    .next_slot  (next_slot),
    .fb_rd_en   (fb_rd_en),
    .fb_addr    (fb_addr),
    .fb_rdata   (fb_rdata),
    .anode_sdata(anode_sdata),
    .anode_sclk (anode_sclk),
    .anode_lat  (anode_lat)
  );

  vfd_grid_feeder #(
    .NUM_GRIDS (NUM_GRIDS),
    .SHIFT_BITS(SHIFT_BITS)
  ) u_grid (
    .clk       (clk),
    .rst       (rst),
    .sh_lo     (stb.sh_lo),
    .latch     (stb.latch),
    .bit_idx   (bit_idx),
    .next_slot (next_slot),
    .running   (running),
    .grid_sdata(grid_sdata),
    .grid_sclk (grid_sclk),
    .grid_lat  (grid_lat)
  );

  assert_latch_pair_R2: assert property (@(posedge clk) disable iff (rst)
    anode_lat == grid_lat);
  assert_latch_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    anode_lat |=> !anode_lat);
  assert_blank_moves_at_latch_R7: assert property (@(posedge clk) disable iff (rst)
    ((blank_set_ad != $past(blank_set_ad)) || (blank_set_bc != $past(blank_set_bc)))
      |-> anode_lat);
  assert_single_set_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    !grid_blank |-> (blank_set_ad ^ blank_set_bc));
  assert_grid_unblank_at_latch_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(grid_blank) |-> grid_lat);

endmodule

// File: tb/test_vfd_overlap_scan.sv
`timescale 1ns/1ps
module test_vfd_overlap_scan;
  localparam int G  = 8;
  localparam int A  = 8;
  localparam int SC = 24;
  localparam int GW = $clog2(G);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fb_rd_en;
  logic [GW-1:0] fb_addr;
  logic [A-1:0]  fb_rdata = '0;
  logic anode_sdata, anode_sclk, anode_lat, blank_set_ad, blank_set_bc;
  logic grid_sdata, grid_sclk, grid_lat, grid_blank;

  int checks = 0;
  int errors = 0;
  int epoch  = 0;

  logic [A-1:0] a_sr = '0, a_out = '0;
  logic [G-1:0] g_sr = '0, g_out = '0;
  int a_rises = 0, g_rises = 0, reads = 0, last_addr = -1;

  always #2 clk = ~clk;

  vfd_overlap_scan #(.NUM_GRIDS(G), .NUM_ANODES(A), .SLOT_CLKS(SC)) i_vfd_overlap_scan (
    .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .anode_sdata(anode_sdata), .anode_sclk(anode_sclk), .anode_lat(anode_lat),
    .blank_set_ad(blank_set_ad), .blank_set_bc(blank_set_bc),
    .grid_sdata(grid_sdata), .grid_sclk(grid_sclk), .grid_lat(grid_lat),
    .grid_blank(grid_blank));

  function automatic logic [A-1:0] col_data(int c, int ep);
    if (c == 2) return '1;
    if (c == 5) return '0;
    return A'((c * 53 + 17 + ep * 91) ^ (c << 5));
  endfunction

  function automatic logic [G-1:0] grid_exp(int s);
    logic [G-1:0] v = '0;
    if (s == 0) begin v[0] = 1'b1; v[G-1] = 1'b1; end
    else begin v[s-1] = 1'b1; v[s] = 1'b1; end
    return v;
  endfunction

  // frame buffer read port, one cycle latency
  always @(posedge clk) begin
    if (fb_rd_en) begin
      fb_rdata <= col_data(int'(fb_addr), epoch);
      last_addr = int'(fb_addr);
      reads = reads + 1;
    end
  end

  // driver models
  always @(posedge anode_sclk) begin a_sr = {a_sr[A-2:0], anode_sdata}; a_rises = a_rises + 1; end
  always @(posedge grid_sclk)  begin g_sr = {g_sr[G-2:0], grid_sdata};  g_rises = g_rises + 1; end
  always @(posedge anode_lat) a_out = a_sr;
  always @(posedge grid_lat)  g_out = g_sr;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check(blank_set_ad == 1'b1, req, blank_set_ad, 1);
    check(blank_set_bc == 1'b1, req, blank_set_bc, 1);
    check(grid_blank == 1'b1, req, grid_blank, 1);
    check(anode_lat == 1'b0 && grid_lat == 1'b0, req, {anode_lat, grid_lat}, 0);
    check(anode_sclk == 1'b1 && grid_sclk == 1'b1, req, {anode_sclk, grid_sclk}, 3);
    check(fb_rd_en == 1'b0, req, fb_rd_en, 0);
  endtask

  task automatic clear_counts();
    a_rises = 0; g_rises = 0; reads = 0;
  endtask

  task automatic run_slots(input int n);
    int  s = 0;
    bit  first = 1'b1;
    for (int i = 0; i < n; i++) begin
      int  cyc = 0, a_low = 0, g_low = 0;
      bit  prep_ok = 1'b1;
      do begin
        @(negedge clk);
        cyc++;
        if (!anode_sclk) a_low++;
        if (!grid_sclk) g_low++;
        if (first && !anode_lat && !(blank_set_ad && blank_set_bc && grid_blank)) prep_ok = 1'b0;
      end while (!anode_lat && cyc < 1000);
      if (!first) check(cyc == SC, "R2 slot period", cyc, SC);
      check(grid_lat == 1'b1, "R2 latch pair", grid_lat, 1);
      check(a_rises == A, "R5 anode edges", a_rises, A);
      check(g_rises == (first ? G : 1), "R4 grid edges", g_rises, first ? G : 1);
      check(a_low == A, "R8 anode idle high", a_low, A);
      check(g_low == (first ? G : 1), "R8 grid idle high", g_low, first ? G : 1);
      check(reads == 1, "R6 one read", reads, 1);
      check(last_addr == s, "R6 read address", last_addr, s);
      check(a_out == col_data(s, epoch), "R5 anode column", a_out, col_data(s, epoch));
      check(g_out == grid_exp(s), "R3 grid pair", g_out, grid_exp(s));
      check(blank_set_ad == 1'(s % 2), "R7 blank A+D", blank_set_ad, s % 2);
      check(blank_set_bc == 1'((s + 1) % 2), "R7 blank B+C", blank_set_bc, (s + 1) % 2);
      check(grid_blank == 1'b0, "R9 grid unblanked", grid_blank, 0);
      check(anode_sclk && grid_sclk, "R8 clocks high at latch", {anode_sclk, grid_sclk}, 3);
      if (first) check(prep_ok, "R9 preparation blanked", prep_ok, 1);
      clear_counts();
      s = (s + 1) % G;
      first = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check_idle("R1 reset state");
    rst = 1'b0;
    clear_counts();
    run_slots(3 * G + 1);       // sweeps three refresh cycles across the wrap
    repeat (7) @(negedge clk);  // land mid-slot
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R10 mid-slot reset");
    epoch = 1;
    rst = 1'b0;
    clear_counts();
    run_slots(G + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule